// File: doc/BRIEF.md
# Address learning and flow assignment engine

This block sits in the forwarding path of an 8-port layer 2 switch. For each received frame the parser passes in the source address, the destination address and the ingress port. The block then does three things. It learns which port the source address sits behind. It chooses the egress ports for the frame. It gives the source/destination pair a flow identifier that a downstream queue scheduler uses to keep per-flow fairness. No port map is set up by hand: every association comes from observed source addresses.

Two instances of the block can keep their learning tables in step. Each address/port pair that one instance learns, or moves to a new port, is offered on an export stream. Pairs that the peer learned come in on an import stream and are installed directly.

The block has four streams, and each uses a valid/ready handshake:
- **Frame stream (in).** A frame is taken in on a cycle where `req_valid` and `req_ready` are both high.
- **Result stream (out).** Each accepted frame produces exactly one result.
- **Export stream (out).** Carries newly learned or moved address/port pairs.
- **Import stream (in).** Carries pairs learned by the peer.

`req_ready` stays low while either output slot holds an unread value that is not being taken this cycle. A source keeps its offer stable until it is accepted. An output holds its value until it is taken.

Top module: `mac_learn_flow`

## Requirements
- R1: `req_ready` is high exactly when two conditions both hold: `res_valid` is low or `res_ready` is high, and `exp_valid` is low or `exp_ready` is high. An accepted frame's result is shown with `res_valid` on the next cycle. While `res_ready` is low the result holds its mask and flow value unchanged.
- R2: If the destination address is not in the table, the result mask has every port bit set except the ingress bit. Bit i of the mask stands for port i.
- R3: The all-ones destination address always gets the mask from R2, whatever the table holds.
- R4: If the destination address is in the table on a port other than the ingress port, the mask has only that port's bit set.
- R5: If the destination address is in the table on the ingress port, the mask is zero. The frame is dropped, but its result is still delivered.
- R6: An accepted frame writes {source address, ingress port} into the address table slot given by the address fold. The fold is a 4-bit index: bit k is the XOR of every address bit i with i mod 4 = k. This write overwrites any other address in that slot and moves a known address to a new port. The write is visible to the next frame's lookup. The frame's own lookup sees the table as it was before.
- R7: If the R6 write changes the slot, the pair {source address, ingress port} is shown on the export stream on the next cycle. It is held there until `exp_ready` is high. If the source address is already stored with the same port, nothing is exported.
- R8: `imp_ready` is the inverse of (`req_valid` and `req_ready`). An accepted import pair is written into its fold slot in the same way as R6, and it is never exported.
- R9: Flow entries sit in a 32-slot table. The slot index is the 5-bit fold (bit k is the XOR of bits i with i mod 5 = k) of source XOR destination. A pair that is already stored returns its stored identifier. Any other pair takes the 10-bit allocation counter's value, which then goes up by one and wraps from 1023 to 0, and that pair replaces the slot.
- R10: After reset, every table slot is empty, the allocation counter is 0, `res_valid` and `exp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame header offered |
| req_ready | output | 1 | Frame header accepted this cycle if valid |
| req_sa | input | 48 | Source address |
| req_da | input | 48 | Destination address |
| req_port | input | 3 | Ingress port |
| res_valid | output | 1 | Forwarding result available |
| res_ready | input | 1 | Result consumer takes the result |
| res_mask | output | 8 | Egress port mask, bit i = port i |
| res_flow | output | 10 | Flow identifier |
| exp_valid | output | 1 | Learned pair offered to peer |
| exp_ready | input | 1 | Peer takes the pair |
| exp_mac | output | 48 | Learned address |
| exp_port | output | 3 | Port of learned address |
| imp_valid | input | 1 | Peer pair offered |
| imp_ready | output | 1 | Peer pair accepted this cycle if valid |
| imp_mac | input | 48 | Peer address |
| imp_port | input | 3 | Peer port |

## Verification
Some rules are checked by the assertions on every cycle:
- Both output streams stay stable while stalled.
- A forwarded mask never contains the ingress port.
- A known destination on another port gives exactly one mask bit.
- Every learning write is followed by an export of that pair.
- The allocation counter goes up by one only on a flow miss.
- Local learning and import never write the address table in the same cycle.

Other behaviours can only be shown by the bench's reference model over long mixed runs:
- Table contents and slot collisions between addresses that fold alike.
- Ports moving from one frame to the next.
- Drops when the destination is known on the ingress port.
- Imported entries steering later frames.
- Flow identifiers being reused or reassigned, and the counter wrapping after many allocations.

// File: rtl/mlf_pkg.sv
package mlf_pkg;
  localparam int unsigned MAC_W = 48;
  typedef logic [MAC_W-1:0] mac_t;
  localparam mac_t BCAST = '1;

  // XOR fold of an address down to w bits (bit i feeds bit i mod w)
  function automatic logic [15:0] fold48(input mac_t a, input int unsigned w);
    logic [15:0] h;
    h = '0;
    for (int unsigned i = 0; i < MAC_W; i++) h[i % w] = h[i % w] ^ a[i];
    return h;
  endfunction
endpackage

// File: rtl/mlf_mac_table.sv
module mlf_mac_table
  import mlf_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned PORT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mac_t              da_mac,
  output logic              da_hit,
  output logic [PORT_W-1:0] da_port,
  input  mac_t              sa_mac,
  input  logic [PORT_W-1:0] sa_port,
  output logic              sa_same,
  input  logic              lrn_we,
  input  logic              imp_we,
  input  mac_t              imp_mac,
  input  logic [PORT_W-1:0] imp_port
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic              ent_v    [DEPTH];
  mac_t              ent_mac  [DEPTH];
  logic [PORT_W-1:0] ent_port [DEPTH];

  logic [IDX_W-1:0] da_idx, sa_idx, imp_idx, wr_idx;
  logic             wr_en;
  mac_t             wr_mac;
  logic [PORT_W-1:0] wr_port;

  always_comb begin
    da_idx  = fold48(da_mac, IDX_W)[IDX_W-1:0];
    sa_idx  = fold48(sa_mac, IDX_W)[IDX_W-1:0];
    imp_idx = fold48(imp_mac, IDX_W)[IDX_W-1:0];
    da_hit  = ent_v[da_idx] && (ent_mac[da_idx] == da_mac);
    da_port = ent_port[da_idx];
    sa_same = ent_v[sa_idx] && (ent_mac[sa_idx] == sa_mac) && (ent_port[sa_idx] == sa_port);
    wr_en   = lrn_we || imp_we;
    wr_idx  = lrn_we ? sa_idx  : imp_idx;
    wr_mac  = lrn_we ? sa_mac  : imp_mac;
    wr_port = lrn_we ? sa_port : imp_port;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_v[i] <= 1'b0;
    end else if (wr_en) begin
      ent_v[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_mac[wr_idx]  <= wr_mac;
      ent_port[wr_idx] <= wr_port;
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(lrn_we && imp_we)); // R8

  AST_LEARN_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    lrn_we |=> (ent_v[$past(sa_idx)] && ent_mac[$past(sa_idx)] == $past(sa_mac))); // R6
endmodule

// File: rtl/mlf_flow_table.sv
module mlf_flow_table
  import mlf_pkg::*;
#(
  parameter int unsigned FIDX_W = 5,
  parameter int unsigned FLOW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  mac_t              sa,
  input  mac_t              da,
  output logic [FLOW_W-1:0] flow_id
);
  localparam int unsigned DEPTH = 1 << FIDX_W;

  logic              f_v   [DEPTH];
  mac_t              f_sa  [DEPTH];
  mac_t              f_da  [DEPTH];
  logic [FLOW_W-1:0] f_id  [DEPTH];
  logic [FLOW_W-1:0] next_id;
  logic [FIDX_W-1:0] idx;
  logic              hit;

  always_comb begin
    idx     = fold48(sa ^ da, FIDX_W)[FIDX_W-1:0];
    hit     = f_v[idx] && (f_sa[idx] == sa) && (f_da[idx] == da);
    flow_id = hit ? f_id[idx] : next_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_id <= '0;
      for (int i = 0; i < DEPTH; i++) f_v[i] <= 1'b0;
    end else if (lk_en && !hit) begin
      next_id  <= next_id + 1'b1;
      f_v[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_en && !hit) begin
      f_sa[idx] <= sa;
      f_da[idx] <= da;
      f_id[idx] <= next_id;
    end
  end

  AST_ALLOC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !hit) |=> (next_id == $past(next_id) + 1'b1)); // R9

  AST_HIT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_en && !hit) |=> $stable(next_id)); // R9
endmodule

// File: rtl/mlf_egress.sv
module mlf_egress
  import mlf_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned PORT_W  = 3
) (
  input  mac_t               da,
  input  logic [PORT_W-1:0]  in_port,
  input  logic               da_hit,
  input  logic [PORT_W-1:0]  da_port,
  output logic [N_PORTS-1:0] mask
);
  localparam logic [N_PORTS-1:0] ONE = {{(N_PORTS-1){1'b0}}, 1'b1};

  logic flood;

  always_comb begin
    flood = (da == BCAST) || !da_hit;
    if (flood)                  mask = ~(ONE << in_port);
    else if (da_port == in_port) mask = '0;
    else                        mask = ONE << da_port;
  end
endmodule

// File: rtl/mac_learn_flow.sv
module mac_learn_flow
  import mlf_pkg::*;
#(
  parameter int unsigned N_PORTS    = 8,
  parameter int unsigned MAC_IDX_W  = 4,
  parameter int unsigned FLOW_IDX_W = 5,
  parameter int unsigned FLOW_W     = 10,
  localparam int unsigned PORT_W    = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [47:0]        req_sa,
  input  logic [47:0]        req_da,
  input  logic [PORT_W-1:0]  req_port,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [N_PORTS-1:0] res_mask,
  output logic [FLOW_W-1:0]  res_flow,
  output logic               exp_valid,
  input  logic               exp_ready,
  output logic [47:0]        exp_mac,
  output logic [PORT_W-1:0]  exp_port,
  input  logic               imp_valid,
  output logic               imp_ready,
  input  logic [47:0]        imp_mac,
  input  logic [PORT_W-1:0]  imp_port
);
  logic               req_fire, imp_fire, learn;
  logic               da_hit, sa_same;
  logic [PORT_W-1:0]  da_port;
  logic [N_PORTS-1:0] eg_mask;
  logic [FLOW_W-1:0]  flow_c;

  assign req_ready = (!res_valid || res_ready) && (!exp_valid || exp_ready);
  assign req_fire  = req_valid && req_ready;
  assign imp_ready = !req_fire;
  assign imp_fire  = imp_valid && imp_ready;
  assign learn     = req_fire && !sa_same;

  mlf_mac_table #(.IDX_W(MAC_IDX_W), .PORT_W(PORT_W)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .da_mac(req_da), .da_hit(da_hit), .da_port(da_port),
    .sa_mac(req_sa), .sa_port(req_port), .sa_same(sa_same),
    .lrn_we(learn), .imp_we(imp_fire), .imp_mac(imp_mac), .imp_port(imp_port)
  );

  mlf_egress #(.N_PORTS(N_PORTS), .PORT_W(PORT_W)) u_eg (
    .da(req_da), .in_port(req_port), .da_hit(da_hit), .da_port(da_port), .mask(eg_mask)
  );

  mlf_flow_table #(.FIDX_W(FLOW_IDX_W), .FLOW_W(FLOW_W)) u_flow (
    .clk(clk), .rst_n(rst_n), .lk_en(req_fire), .sa(req_sa), .da(req_da), .flow_id(flow_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_mask  <= '0;
      res_flow  <= '0;
    end else if (req_fire) begin
      res_valid <= 1'b1;
      res_mask  <= eg_mask;
      res_flow  <= flow_c;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_mac   <= '0;
      exp_port  <= '0;
    end else if (learn) begin
      exp_valid <= 1'b1;
      exp_mac   <= req_sa;
      exp_port  <= req_port;
    end else if (exp_ready) begin
      exp_valid <= 1'b0;
    end
  end

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_mask) && $stable(res_flow))); // R1

  AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_valid && !exp_ready) |=> (exp_valid && $stable(exp_mac) && $stable(exp_port))); // R7

  AST_EXP_AFTER_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
    learn |=> (exp_valid && exp_mac == $past(req_sa) && exp_port == $past(req_port))); // R7

  AST_NO_REFLECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> !eg_mask[req_port]); // R2

  AST_KNOWN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && da_hit && req_da != BCAST && da_port != req_port)
      |-> ($countones(eg_mask) == 1)); // R4

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (res_valid && res_mask == $past(eg_mask))); // R1
endmodule

// File: tb/mac_learn_flow_tb.sv
module mac_learn_flow_tb_top;
  localparam int MI = 4;
  localparam int FI = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, res_ready = 0, exp_ready = 0, imp_valid = 0;
  logic [47:0] req_sa = '0, req_da = '0, imp_mac = '0;
  logic [2:0]  req_port = '0, imp_port = '0;
  logic req_ready, res_valid, exp_valid, imp_ready;
  logic [7:0] res_mask;
  logic [9:0] res_flow;
  logic [47:0] exp_mac;
  logic [2:0] exp_port;

  mac_learn_flow dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_sa(req_sa), .req_da(req_da), .req_port(req_port),
    .res_valid(res_valid), .res_ready(res_ready), .res_mask(res_mask), .res_flow(res_flow),
    .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_mac(exp_mac), .exp_port(exp_port),
    .imp_valid(imp_valid), .imp_ready(imp_ready), .imp_mac(imp_mac), .imp_port(imp_port)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic int fold(input logic [47:0] a, input int w);
    int h = 0;
    for (int i = 0; i < 48; i++) if (a[i]) h = h ^ (1 << (i % w));
    return h;
  endfunction

  // reference model state
  bit          m_v   [16];
  logic [47:0] m_mac [16];
  int          m_prt [16];
  bit          m_imp [16];
  bit          f_v   [32];
  logic [47:0] f_sa  [32];
  logic [47:0] f_da  [32];
  int          f_id  [32];
  int          cnt;
  bit          e_res_v, e_exp_v;
  int          e_mask, e_flow, e_exp_port;
  logic [47:0] e_exp_mac;
  string       e_tag;
  bit          req_pend, imp_pend;

  function automatic bit m_rdy();
    return (!e_res_v || res_ready) && (!e_exp_v || exp_ready);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      foreach (f_v[i]) f_v[i] = 0;
      cnt = 0; e_res_v = 0; e_exp_v = 0; req_pend = 0; imp_pend = 0;
    end else begin
      bit fire, ifire;
      fire  = req_valid && m_rdy();
      ifire = imp_valid && !fire;
      req_pend = req_valid && !fire;
      imp_pend = imp_valid && !ifire;
      if (e_res_v && res_ready) e_res_v = 0;
      if (e_exp_v && exp_ready) e_exp_v = 0;
      if (fire) begin
        int di, si, fx;
        di = fold(req_da, MI);
        if (req_da == '1) begin e_mask = 8'hFF & ~(1 << req_port); e_tag = "R3"; end
        else if (!(m_v[di] && m_mac[di] == req_da)) begin e_mask = 8'hFF & ~(1 << req_port); e_tag = "R2"; end
        else if (m_prt[di] == int'(req_port)) begin e_mask = 0; e_tag = "R5"; end
        else begin e_mask = 1 << m_prt[di]; e_tag = m_imp[di] ? "R8" : "R4 R6"; end
        fx = fold(req_sa ^ req_da, FI);
        if (f_v[fx] && f_sa[fx] == req_sa && f_da[fx] == req_da) e_flow = f_id[fx];
        else begin
          e_flow = cnt; f_v[fx] = 1; f_sa[fx] = req_sa; f_da[fx] = req_da; f_id[fx] = cnt;
          cnt = (cnt + 1) % 1024; // R9 wrap
        end
        e_res_v = 1;
        si = fold(req_sa, MI);
        if (!(m_v[si] && m_mac[si] == req_sa && m_prt[si] == int'(req_port))) begin
          m_v[si] = 1; m_mac[si] = req_sa; m_prt[si] = req_port; m_imp[si] = 0;
          e_exp_v = 1; e_exp_mac = req_sa; e_exp_port = req_port;
        end
      end
      if (ifire) begin
        int ii;
        ii = fold(imp_mac, MI);
        m_v[ii] = 1; m_mac[ii] = imp_mac; m_prt[ii] = imp_port; m_imp[ii] = 1;
      end
    end
  end

  logic [47:0] pool [12];
  int home [12];

  initial begin
    for (int i = 0; i < 12; i++) begin
      pool[i] = {8'h02, 8'(i * 37), 32'h5A00_0000 + 32'(i * 32'h0103_0507)};
      home[i] = i % 8;
    end
    pool[1] = pool[0] ^ 48'h11;          // same 4-bit fold as pool[0]: R6 collision
    pool[2] = pool[0] ^ 48'h0000_0001_0001;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 0, "R10 res_valid", res_valid, 0);
    check(exp_valid == 0, "R10 exp_valid", exp_valid, 0);
    check(req_ready == 1, "R10 req_ready", req_ready, 1);
    for (int cyc = 0; cyc < 12000; cyc++) begin
      // compare outputs against model
      check(req_ready == m_rdy(), "R1 req_ready", req_ready, m_rdy());
      check(res_valid == e_res_v, "R1 res_valid", res_valid, e_res_v);
      if (res_valid && e_res_v) begin
        check(res_mask == 8'(e_mask), e_tag, res_mask, e_mask);
        check(res_flow == 10'(e_flow), "R9 flow", res_flow, e_flow);
      end
      check(exp_valid == e_exp_v, "R7 exp_valid", exp_valid, e_exp_v);
      if (exp_valid && e_exp_v) begin
        check(exp_mac == e_exp_mac, "R7 exp_mac", exp_mac, e_exp_mac);
        check(exp_port == 3'(e_exp_port), "R7 exp_port", exp_port, e_exp_port);
      end
      // new stimulus
      res_ready = ($urandom % 4) != 0;
      exp_ready = ($urandom % 3) != 0;
      if (!req_pend) begin
        int s, d;
        req_valid = ($urandom % 4) != 0;
        s = $urandom % 12;
        d = $urandom % 14;
        if ($urandom % 10 == 0) home[s] = $urandom % 8;
        req_sa = pool[s];
        req_port = 3'(home[s]);
        if (d < 12) req_da = pool[d];
        else if (d == 12) req_da = '1;
        else req_da = {16'hBEEF, 32'($urandom)};
      end
      if (!imp_pend) begin
        imp_valid = ($urandom % 5) == 0;
        imp_mac = pool[8 + ($urandom % 4)];
        imp_port = 3'($urandom % 8);
      end
      @(negedge clk);
      check(imp_ready == !(req_valid && req_ready), "R8 imp_ready", imp_ready, !(req_valid && req_ready));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule